// File: doc/BRIEF.md
# Memory Protection Control and Access Arbiter

This block owns the single control register of a memory protection unit and, for every memory access the core presents, decides whether the access goes ahead or raises a memory-management fault. An access that goes ahead either takes its attributes from a matching programmed region or falls back to the default memory map. The base/size comparators and the per-region attribute storage sit outside this block. Their results arrive here as a per-region hit vector, already qualified by each region's own enable, together with privileged-only, read-only and execute-never bits for each region.

Software reaches the control register through a small register port: word address, write data, write and read strobes, and a privilege flag. The access side is purely combinational. The core presents the privilege level, the write and instruction-fetch flags, the signed execution priority and the system-control-space and vector-table flags, and it receives allow, default-map and fault in the same cycle. Priorities −1 and −2 (hard fault, NMI and fault-masked handlers) get special treatment, and a background map can stand in as the lowest-priority region for privileged software.

Top module: `mpu_guard`

## Requirements
- R1: The control register sits at word address CTRL_OFFSET (default 0xD94). Its fields are bit 0 = global enable, bit 1 = check-in-fault-handlers enable and bit 2 = privileged background-map enable. Bits above 2 read as zero, and all three fields are 0 after reset. regRdata updates on the clock edge that samples regRe high and holds otherwise. A privileged read of CTRL_OFFSET returns the fields as they stood before any write in the same cycle. A read of any other address returns zero.
- R2: A write with regPriv low leaves the register unchanged. If that write targets CTRL_OFFSET, busErr is high for exactly the one cycle after it. An unprivileged read returns zero.
- R3: While global enable is 0, every access except a system-control-space fetch is allowed with accDefault high.
- R4: With the check active and no region hit, an access that is not a system-control-space or vector-table access is allowed on the default map only when it is privileged and background enable is 1. Otherwise it faults.
- R5: accHit is high when any bit of regionHit is set. accRegion is the highest set index, or 0 when none is set.
- R6: With the check active and at least one hit (outside the system control space and vector table), the highest-numbered hit region decides the outcome. The access faults if it is unprivileged and the region is privileged-only, if it is a write and the region is read-only, or if it is a fetch and the region is execute-never. Otherwise it is allowed with accDefault low.
- R7: With the check active, system-control-space and vector-table accesses are allowed on the default map regardless of the region inputs.
- R8: The check is active only when global enable is 1 and either the execution priority is neither −1 nor −2 or the fault-handler enable is 1. Otherwise accesses other than system-control-space fetches are allowed on the default map.
- R9: An instruction fetch flagged as system control space always faults, whatever the register holds.
- R10: cfgConflict is high exactly when the fault-handler enable is 1 and global enable is 0. That combination behaves as disabled.
- R11: accFault is the complement of accAllow, and accDefault is high only when accAllow is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register word address |
| regWdata | input | DATA_W | Register write data |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regPriv | input | 1 | Register access is privileged |
| regRdata | output | DATA_W | Registered read data |
| busErr | output | 1 | One-cycle pulse after an unprivileged control write |
| cfgConflict | output | 1 | Fault-handler enable set while global enable clear |
| accPriv | input | 1 | Access is privileged |
| accWrite | input | 1 | Access is a write |
| accExec | input | 1 | Access is an instruction fetch |
| accPrio | input | PRIO_W | Signed current execution priority |
| accScs | input | 1 | Access targets the system control space |
| accVec | input | 1 | Access targets the vector table |
| regionHit | input | NUM_REGIONS | Enabled regions whose range matches |
| regionPrivOnly | input | NUM_REGIONS | Region allows privileged access only |
| regionReadOnly | input | NUM_REGIONS | Region forbids writes |
| regionXn | input | NUM_REGIONS | Region forbids instruction fetch |
| accAllow | output | 1 | Access permitted |
| accDefault | output | 1 | Permitted access uses the default map |
| accFault | output | 1 | Memory-management fault |
| accHit | output | 1 | Some region matched |
| accRegion | output | IDX_W | Index of the deciding region |

## Verification
The bench builds the block with NUM_REGIONS = 4 and keeps the defaults for the address, data and priority widths. With four regions, random hit vectors come out empty one time in sixteen and multi-hit most of the time. The behavioural model therefore meets the background-map path, the highest-index override and every permission-denial reason within a few thousand cycles. Random privileged control writes cycle the three fields through all eight combinations, including the conflict setting. Priorities −1 and −2 are drawn often enough to exercise the bypass both with and without the fault-handler enable.

// File: rtl/mpu_guard_pkg.sv
package mpu_guard_pkg;

  // Field positions inside the control word; software depends on these.
  localparam int ENABLE_BIT  = 0;
  localparam int FAULTEN_BIT = 1;
  localparam int BGMAP_BIT   = 2;
  localparam int CTRL_BITS   = 3;

  // Strobes handed from the register side to the decision datapath.
  typedef struct packed {
    logic bgMap;
    logic faultEn;
    logic enable;
  } ctrl_strobes_t;

endpackage

// File: rtl/mpu_ctrl_regs.sv
module mpu_ctrl_regs
  import mpu_guard_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 12'hD94
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              regWe,
  input  logic              regRe,
  input  logic              regPriv,
  output logic [DATA_W-1:0] regRdata,
  output logic              busErr,
  output ctrl_strobes_t     ctrlOut,
  output logic              cfgConflict
);

  logic              addrHit;
  logic              privWrite;
  logic              userWrite;
  logic [DATA_W-1:0] readWord;
  ctrl_strobes_t     ctrlQ;

  assign addrHit   = (regAddr == CTRL_OFFSET);
  assign privWrite = regWe && addrHit && regPriv;
  assign userWrite = regWe && addrHit && !regPriv;

  always_comb begin
    readWord              = '0;
    readWord[ENABLE_BIT]  = ctrlQ.enable;
    readWord[FAULTEN_BIT] = ctrlQ.faultEn;
    readWord[BGMAP_BIT]   = ctrlQ.bgMap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      regRdata <= '0;
      busErr   <= 1'b0;
    end else begin
      busErr <= userWrite;
      if (privWrite) begin
        ctrlQ.enable  <= regWdata[ENABLE_BIT];
        ctrlQ.faultEn <= regWdata[FAULTEN_BIT];
        ctrlQ.bgMap   <= regWdata[BGMAP_BIT];
      end
      if (regRe) begin
        regRdata <= (addrHit && regPriv) ? readWord : '0;
      end
    end
  end

  assign ctrlOut     = ctrlQ;
  assign cfgConflict = ctrlQ.faultEn && !ctrlQ.enable;

  // R1: reserved bits never show up on the read port
  p_rsv_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[DATA_W-1:CTRL_BITS] == '0);

  // R2: an unprivileged write cannot alter the register
  p_user_nowrite_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !regPriv) |=> $stable(ctrlOut));

  // R2: a bus error always traces back to an unprivileged control write
  p_buserr_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(regWe && !regPriv && regAddr == CTRL_OFFSET));

  // R2: an unprivileged read never returns data
  p_user_read_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regRe && !regPriv) |=> (regRdata == '0));

endmodule

// File: rtl/mpu_decide.sv
module mpu_decide
  import mpu_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int PRIO_W      = 9,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrl_strobes_t            ctrl,
  input  logic                     accPriv,
  input  logic                     accWrite,
  input  logic                     accExec,
  input  logic signed [PRIO_W-1:0] accPrio,
  input  logic                     accScs,
  input  logic                     accVec,
  input  logic [NUM_REGIONS-1:0]   regionHit,
  input  logic [NUM_REGIONS-1:0]   regionPrivOnly,
  input  logic [NUM_REGIONS-1:0]   regionReadOnly,
  input  logic [NUM_REGIONS-1:0]   regionXn,
  output logic                     accAllow,
  output logic                     accDefault,
  output logic                     accFault,
  output logic                     accHit,
  output logic [IDX_W-1:0]         accRegion
);

  localparam logic signed [PRIO_W-1:0] PRIO_M1 = '1;
  localparam logic signed [PRIO_W-1:0] PRIO_M2 = {{(PRIO_W-1){1'b1}}, 1'b0};

  logic [NUM_REGIONS-1:0] denyVec;
  logic [IDX_W-1:0]       winner;
  logic                   anyHit;
  logic                   escalated;
  logic                   checkOn;
  logic                   scsFetch;

  // Per-region permission verdicts
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_deny
    assign denyVec[g] = (!accPriv && regionPrivOnly[g]) ||
                        (accWrite && regionReadOnly[g]) ||
                        (accExec  && regionXn[g]);
  end

  // Highest-numbered hit wins; later iterations overwrite earlier ones
  always_comb begin
    winner = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (regionHit[i]) winner = IDX_W'(i);
    end
  end

  assign anyHit    = |regionHit;
  assign escalated = (accPrio == PRIO_M1) || (accPrio == PRIO_M2);
  assign checkOn   = ctrl.enable && (ctrl.faultEn || !escalated);
  assign scsFetch  = accScs && accExec;

  always_comb begin
    accAllow   = 1'b0;
    accDefault = 1'b0;
    if (scsFetch) begin
      accAllow = 1'b0;
    end else if (!checkOn) begin
      accAllow   = 1'b1;
      accDefault = 1'b1;
    end else if (accScs || accVec) begin
      accAllow   = 1'b1;
      accDefault = 1'b1;
    end else if (anyHit) begin
      accAllow = !denyVec[winner];
    end else if (accPriv && ctrl.bgMap) begin
      accAllow   = 1'b1;
      accDefault = 1'b1;
    end
  end

  assign accFault  = !accAllow;
  assign accHit    = anyHit;
  assign accRegion = winner;

  // R9: a fetch from the system control space is never let through
  p_scs_fetch_r9: assert property (@(posedge clk) disable iff (!rstN)
    (accScs && accExec) |-> accFault);

  // R3: with the unit switched off everything else is default-map
  p_off_default_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.enable && !(accScs && accExec)) |-> (accAllow && accDefault));

  // R8: escalated handlers bypass the check unless the fault-handler bit is set
  p_bypass_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.enable && !ctrl.faultEn && (accPrio == PRIO_M1 || accPrio == PRIO_M2)
     && !(accScs && accExec)) |-> (accAllow && accDefault));

  // R11: the default-map flag only accompanies an allowed access
  p_default_allow_r11: assert property (@(posedge clk) disable iff (!rstN)
    accDefault |-> accAllow);

  // R5: the reported region is really one that hit
  p_region_hit_r5: assert property (@(posedge clk) disable iff (!rstN)
    accHit |-> regionHit[accRegion]);

  // R6: a region decision never selects the default map
  p_region_nodefault_r6: assert property (@(posedge clk) disable iff (!rstN)
    (checkOn && anyHit && !accScs && !accVec) |-> !accDefault);

endmodule

// File: rtl/mpu_guard.sv
module mpu_guard
  import mpu_guard_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int NUM_REGIONS = 8,
  parameter int PRIO_W      = 9,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 12'hD94,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [DATA_W-1:0]        regWdata,
  input  logic                     regWe,
  input  logic                     regRe,
  input  logic                     regPriv,
  output logic [DATA_W-1:0]        regRdata,
  output logic                     busErr,
  output logic                     cfgConflict,
  input  logic                     accPriv,
  input  logic                     accWrite,
  input  logic                     accExec,
  input  logic signed [PRIO_W-1:0] accPrio,
  input  logic                     accScs,
  input  logic                     accVec,
  input  logic [NUM_REGIONS-1:0]   regionHit,
  input  logic [NUM_REGIONS-1:0]   regionPrivOnly,
  input  logic [NUM_REGIONS-1:0]   regionReadOnly,
  input  logic [NUM_REGIONS-1:0]   regionXn,
  output logic                     accAllow,
  output logic                     accDefault,
  output logic                     accFault,
  output logic                     accHit,
  output logic [IDX_W-1:0]         accRegion
);

  ctrl_strobes_t ctrlBus;

  mpu_ctrl_regs #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CTRL_OFFSET(CTRL_OFFSET)
  ) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .regWe      (regWe),
    .regRe      (regRe),
    .regPriv    (regPriv),
    .regRdata   (regRdata),
    .busErr     (busErr),
    .ctrlOut    (ctrlBus),
    .cfgConflict(cfgConflict)
  );

  mpu_decide #(
    .NUM_REGIONS(NUM_REGIONS),
    .PRIO_W     (PRIO_W)
  ) u_decide (
    .clk           (clk),
    .rstN          (rstN),
    .ctrl          (ctrlBus),
    .accPriv       (accPriv),
    .accWrite      (accWrite),
    .accExec       (accExec),
    .accPrio       (accPrio),
    .accScs        (accScs),
    .accVec        (accVec),
    .regionHit     (regionHit),
    .regionPrivOnly(regionPrivOnly),
    .regionReadOnly(regionReadOnly),
    .regionXn      (regionXn),
    .accAllow      (accAllow),
    .accDefault    (accDefault),
    .accFault      (accFault),
    .accHit        (accHit),
    .accRegion     (accRegion)
  );

endmodule

// File: tb/tb_mpu_guard.sv
module tb_mpu_guard;

  localparam int AW = 12;
  localparam int DW = 32;
  localparam int NR = 4;
  localparam int PW = 9;
  localparam int IW = 2;
  localparam logic [AW-1:0] OFF = 12'hD94;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] regAddr;
  logic [DW-1:0] regWdata;
  logic          regWe, regRe, regPriv;
  logic [DW-1:0] regRdata;
  logic          busErr, cfgConflict;
  logic          accPriv, accWrite, accExec, accScs, accVec;
  logic signed [PW-1:0] accPrio;
  logic [NR-1:0] regionHit, regionPrivOnly, regionReadOnly, regionXn;
  logic          accAllow, accDefault, accFault, accHit;
  logic [IW-1:0] accRegion;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  mpu_guard #(.NUM_REGIONS(NR)) dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRe(regRe), .regPriv(regPriv), .regRdata(regRdata),
    .busErr(busErr), .cfgConflict(cfgConflict), .accPriv(accPriv),
    .accWrite(accWrite), .accExec(accExec), .accPrio(accPrio),
    .accScs(accScs), .accVec(accVec), .regionHit(regionHit),
    .regionPrivOnly(regionPrivOnly), .regionReadOnly(regionReadOnly),
    .regionXn(regionXn), .accAllow(accAllow), .accDefault(accDefault),
    .accFault(accFault), .accHit(accHit), .accRegion(accRegion)
  );

  // Behavioural reference state
  logic [2:0]    ctrlM;
  logic [DW-1:0] rdataM;
  logic          berrM;
  logic          rdUserM;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlM   <= 3'b000;
      rdataM  <= '0;
      berrM   <= 1'b0;
      rdUserM <= 1'b0;
    end else begin
      berrM <= regWe && (regAddr == OFF) && !regPriv;
      if (regWe && regAddr == OFF && regPriv) ctrlM <= regWdata[2:0];
      if (regRe) begin
        rdUserM <= !regPriv;
        rdataM  <= (regAddr == OFF && regPriv) ? {29'd0, ctrlM} : '0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    logic expA, expD;
    string req;
    int top;
    integer p;
    p   = accPrio;
    top = -1;
    for (int i = NR - 1; i >= 0; i--) begin
      if (top < 0 && regionHit[i]) top = i;
    end
    expA = 1'b0;
    expD = 1'b0;
    if (accScs && accExec) begin
      req = "R9";
    end else if (!ctrlM[0]) begin
      expA = 1'b1; expD = 1'b1;
      req = ctrlM[1] ? "R10" : "R3";
    end else if ((p == -1 || p == -2) && !ctrlM[1]) begin
      expA = 1'b1; expD = 1'b1; req = "R8";
    end else if (accScs || accVec) begin
      expA = 1'b1; expD = 1'b1; req = "R7";
    end else if (top >= 0) begin
      req  = "R6";
      expA = !((!accPriv && regionPrivOnly[top]) ||
               (accWrite && regionReadOnly[top]) ||
               (accExec && regionXn[top]));
    end else begin
      req = "R4";
      if (accPriv && ctrlM[2]) begin
        expA = 1'b1; expD = 1'b1;
      end
    end
    chk(req, {31'd0, accAllow}, {31'd0, expA});
    chk(req, {31'd0, accDefault}, {31'd0, expD});
    chk("R11", {31'd0, accFault}, {31'd0, !expA});
    chk("R5", {31'd0, accHit}, {31'd0, (top >= 0)});
    chk("R5", {30'd0, accRegion}, (top >= 0) ? top : 0);
    chk("R10", {31'd0, cfgConflict}, {31'd0, ctrlM[1] && !ctrlM[0]});
    chk(rdUserM ? "R2" : "R1", regRdata, rdataM);
    chk("R2", {31'd0, busErr}, {31'd0, berrM});
  endtask

  task automatic driveRandom();
    regWe    = ($urandom % 4) == 0;
    regRe    = ($urandom % 3) == 0;
    regAddr  = (($urandom % 4) != 0) ? OFF : AW'($urandom);
    regPriv  = ($urandom % 4) != 0;
    regWdata = $urandom;
    accPriv  = $urandom % 2;
    accWrite = $urandom % 2;
    accExec  = ($urandom % 5) == 0;
    accScs   = ($urandom % 8) == 0;
    accVec   = ($urandom % 8) == 0;
    case ($urandom % 4)
      0: accPrio = PW'(-1);
      1: accPrio = PW'(-2);
      2: accPrio = '0;
      default: accPrio = PW'($urandom % 200);
    endcase
    regionHit      = NR'($urandom);
    regionPrivOnly = NR'($urandom);
    regionReadOnly = NR'($urandom);
    regionXn       = NR'($urandom);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
  endtask

  initial begin
    rstN = 1'b0;
    regAddr = '0; regWdata = '0; regWe = 1'b0; regRe = 1'b0; regPriv = 1'b0;
    accPriv = 1'b0; accWrite = 1'b0; accExec = 1'b0; accPrio = '0;
    accScs = 1'b0; accVec = 1'b0;
    regionHit = '0; regionPrivOnly = '0; regionReadOnly = '0; regionXn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state read back privileged
    regAddr = OFF; regPriv = 1'b1; regRe = 1'b1;
    @(negedge clk);
    checkAll();
    chk("R1", regRdata, 32'd0);
    // R1: privileged write of all ones, then read back only the three fields
    regRe = 1'b0; regWe = 1'b1; regWdata = 32'hFFFF_FFFF;
    @(negedge clk);
    checkAll();
    regWe = 1'b0; regRe = 1'b1;
    @(negedge clk);
    checkAll();
    regRe = 1'b0;
    @(negedge clk);
    checkAll();
    chk("R1", regRdata, 32'd7);
    for (int c = 0; c < 4000; c++) begin
      driveRandom();
      @(negedge clk);
      checkAll();
    end
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

endmodule